// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two direction predictors run side by side. One keeps a short outcome history for each branch address. The other keeps a single shared history of every resolved branch. A third table of small saturating counters tracks, for each global history pattern, which of the two has recently been the better guess, and the final direction comes from whichever one it favours. A prediction is combinational from the current state. The block also returns both component guesses so the pipeline can hand them back when the branch resolves.

At resolution the pipeline presents the branch's word address, its real outcome and the two component guesses it was given. On that clock edge the block trains both components. It moves the selector only when the two components had disagreed, and it shifts the new outcome into both histories. Histories are not updated speculatively. A prediction made in the same cycle as an update therefore sees the state from before that update.

Top module: `tournament_bp`

## Requirements
- R1: After reset every history is zero, every direction counter is weakly not-taken and every selector counter is 1. So for any address `pred_taken`, `pred_local` and `pred_global` are all 0.
- R2: Local path. The per-branch history slot is chosen by XOR-folding all `PC_W` address bits into 10 bits (address bit i goes to slot bit i mod 10). That 10-bit history picks one of 1024 three-bit counters, which start at 3 and predict taken when the value is 4 or more. On update the slot's history shifts left and takes the outcome in at bit 0 (1 = taken).
- R3: Global path. A 12-bit history register picks one of 4096 two-bit counters, which predict taken at 2 or more. Every update shifts the outcome into bit 0 of the register.
- R4: A 4096-entry table of two-bit selector counters is indexed by the global history. A value of 2 or more outputs the global guess. A lower value outputs the local guess.
- R5: On update the selector entry steps one toward the component whose returned guess equalled the outcome, but only when the two returned guesses differ. Otherwise it is left unchanged.
- R6: Both components are trained on every update, whichever one was selected. Their counters step up on taken and down on not-taken.
- R7: A prediction presented in the same cycle as an update reflects the state before that update. The update is visible from the next cycle.
- R8: While `upd_valid` is 0, no table and no history changes, whatever the other update inputs are.
- R9: All counters saturate at their bounds: local 0..7, global and selector 0..3. They never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PC_W | Word address of the branch being predicted |
| pred_taken | output | 1 | Selected direction (1 = taken) |
| pred_local | output | 1 | Local component guess |
| pred_global | output | 1 | Global component guess |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Word address of the resolved branch |
| upd_taken | input | 1 | Actual outcome (1 = taken) |
| upd_local | input | 1 | Local guess returned at prediction time |
| upd_global | input | 1 | Global guess returned at prediction time |

## Verification
Lookup and training can fall in the same cycle: a branch address is being predicted while a resolved branch, often the same one, writes the tables and shifts the histories. The bench provokes this by driving both ports at once on one address. It first judges the combinational outputs against a reference model held at its pre-update state. After the edge it judges them again against the updated model. Every other directed scenario also compares all three outputs with that model on every branch, so collisions between the selector step and component training are covered throughout.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Resolution information handed to the selector
  typedef struct packed {
    logic taken;
    logic loc_guess;
    logic glb_guess;
  } bp_resolve_t;

  // Which component wins when exactly one was right
  typedef enum logic [1:0] {
    WIN_NONE   = 2'd0,
    WIN_LOCAL  = 2'd1,
    WIN_GLOBAL = 2'd2
  } bp_winner_e;

endpackage

// File: rtl/bp_local_comp.sv
module bp_local_comp #(
  parameter int PC_W   = 30,
  parameter int SLOT_W = 10,
  parameter int HIST_W = 10,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   rd_pc,
  output logic              rd_guess,
  input  logic              wr_en,
  input  logic [PC_W-1:0]   wr_pc,
  input  logic              wr_taken
);

  localparam int SLOTS = 1 << SLOT_W;
  localparam int CNTS  = 1 << HIST_W;
  localparam logic [CNT_W-1:0] CMAX  = '1;
  localparam logic [CNT_W-1:0] CINIT = {1'b0, {(CNT_W-1){1'b1}}};

  logic [HIST_W-1:0] hist_tbl [SLOTS];
  logic [CNT_W-1:0]  cnt_tbl  [CNTS];

  logic [SLOT_W-1:0] rd_slot, wr_slot;
  logic [HIST_W-1:0] rd_hist, wr_hist, wr_hist_nxt;
  logic [CNT_W-1:0]  wr_cnt, wr_cnt_nxt;

  // XOR fold of the address into a slot index
  always_comb begin
    rd_slot = '0;
    wr_slot = '0;
    for (int i = 0; i < PC_W; i++) begin
      rd_slot[i % SLOT_W] = rd_slot[i % SLOT_W] ^ rd_pc[i];
      wr_slot[i % SLOT_W] = wr_slot[i % SLOT_W] ^ wr_pc[i];
    end
  end

  assign rd_hist  = hist_tbl[rd_slot];
  assign rd_guess = cnt_tbl[rd_hist][CNT_W-1];

  // Next-state for the written entries
  always_comb begin
    wr_hist     = hist_tbl[wr_slot];
    wr_cnt      = cnt_tbl[wr_hist];
    wr_hist_nxt = {wr_hist[HIST_W-2:0], wr_taken};
    wr_cnt_nxt  = wr_cnt;
    if (wr_taken) begin
      if (wr_cnt != CMAX) wr_cnt_nxt = wr_cnt + CNT_W'(1);
    end else begin
      if (wr_cnt != '0) wr_cnt_nxt = wr_cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) hist_tbl[i] <= '0;
      for (int j = 0; j < CNTS; j++)  cnt_tbl[j]  <= CINIT;
    end else if (wr_en) begin
      hist_tbl[wr_slot] <= wr_hist_nxt;
      cnt_tbl[wr_hist]  <= wr_cnt_nxt;
    end
  end

endmodule

// File: rtl/bp_global_comp.sv
module bp_global_comp #(
  parameter int HIST_W = 12,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] hist,
  output logic              rd_guess,
  input  logic              wr_en,
  input  logic              wr_taken
);

  localparam int CNTS = 1 << HIST_W;
  localparam logic [CNT_W-1:0] CMAX  = '1;
  localparam logic [CNT_W-1:0] CINIT = {1'b0, {(CNT_W-1){1'b1}}};

  logic [CNT_W-1:0] cnt_tbl [CNTS];
  logic [CNT_W-1:0] cur, nxt;

  assign cur      = cnt_tbl[hist];
  assign rd_guess = cur[CNT_W-1];

  always_comb begin
    nxt = cur;
    if (wr_taken) begin
      if (cur != CMAX) nxt = cur + CNT_W'(1);
    end else begin
      if (cur != '0) nxt = cur - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CNTS; i++) cnt_tbl[i] <= CINIT;
    end else if (wr_en) begin
      cnt_tbl[hist] <= nxt;
    end
  end

endmodule

// File: rtl/bp_chooser.sv
module bp_chooser
  import bp_pkg::*;
#(
  parameter int HIST_W = 12,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] hist,
  output logic              use_global,
  input  logic              wr_en,
  input  bp_resolve_t       res,
  output logic [CNT_W-1:0]  cur_val,
  output logic [CNT_W-1:0]  nxt_val
);

  localparam int CNTS = 1 << HIST_W;
  localparam logic [CNT_W-1:0] CMAX  = '1;
  localparam logic [CNT_W-1:0] CINIT = {1'b0, {(CNT_W-1){1'b1}}};

  logic [CNT_W-1:0] sel_tbl [CNTS];
  bp_winner_e       winner;

  assign cur_val    = sel_tbl[hist];
  assign use_global = cur_val[CNT_W-1];

  always_comb begin
    if (res.loc_guess == res.glb_guess)
      winner = WIN_NONE;
    else if (res.glb_guess == res.taken)
      winner = WIN_GLOBAL;
    else
      winner = WIN_LOCAL;
  end

  always_comb begin
    nxt_val = cur_val;
    unique case (winner)
      WIN_GLOBAL: if (cur_val != CMAX) nxt_val = cur_val + CNT_W'(1);
      WIN_LOCAL:  if (cur_val != '0)   nxt_val = cur_val - CNT_W'(1);
      default:    nxt_val = cur_val;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CNTS; i++) sel_tbl[i] <= CINIT;
    end else if (wr_en) begin
      sel_tbl[hist] <= nxt_val;
    end
  end

endmodule

// File: rtl/tournament_bp.sv
module tournament_bp
  import bp_pkg::*;
#(
  parameter int PC_W      = 30,
  parameter int LSLOT_W   = 10,
  parameter int LHIST_W   = 10,
  parameter int LCNT_W    = 3,
  parameter int GHIST_W   = 12,
  parameter int GCNT_W    = 2,
  parameter int SEL_W     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic            pred_local,
  output logic            pred_global,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_local,
  input  logic            upd_global
);

  logic [GHIST_W-1:0] ghist_q, ghist_d;
  logic               use_global;
  logic [SEL_W-1:0]   cho_cur, cho_nxt;
  bp_resolve_t        res;

  assign res = '{taken: upd_taken, loc_guess: upd_local, glb_guess: upd_global};

  bp_local_comp #(
    .PC_W(PC_W), .SLOT_W(LSLOT_W), .HIST_W(LHIST_W), .CNT_W(LCNT_W)
  ) u_local (
    .clk(clk), .rst_n(rst_n),
    .rd_pc(pred_pc), .rd_guess(pred_local),
    .wr_en(upd_valid), .wr_pc(upd_pc), .wr_taken(upd_taken)
  );

  bp_global_comp #(
    .HIST_W(GHIST_W), .CNT_W(GCNT_W)
  ) u_global (
    .clk(clk), .rst_n(rst_n),
    .hist(ghist_q), .rd_guess(pred_global),
    .wr_en(upd_valid), .wr_taken(upd_taken)
  );

  bp_chooser #(
    .HIST_W(GHIST_W), .CNT_W(SEL_W)
  ) u_chooser (
    .clk(clk), .rst_n(rst_n),
    .hist(ghist_q), .use_global(use_global),
    .wr_en(upd_valid), .res(res),
    .cur_val(cho_cur), .nxt_val(cho_nxt)
  );

  assign pred_taken = use_global ? pred_global : pred_local;

  // Shared outcome history
  always_comb begin
    ghist_d = ghist_q;
    if (upd_valid) ghist_d = {ghist_q[GHIST_W-2:0], upd_taken};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ghist_q <= '0;
    else        ghist_q <= ghist_d;
  end

endmodule

// File: rtl/tournament_bp_chk.sv
module tournament_bp_chk #(
  parameter int GHIST_W = 12,
  parameter int SEL_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               upd_valid,
  input logic               upd_taken,
  input logic               upd_local,
  input logic               upd_global,
  input logic               pred_local,
  input logic               pred_global,
  input logic               pred_taken,
  input logic [GHIST_W-1:0] ghist,
  input logic [SEL_W-1:0]   cho_cur,
  input logic [SEL_W-1:0]   cho_nxt
);

  AST_GHIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ghist == {$past(ghist[GHIST_W-2:0]), $past(upd_taken)}); // R3

  AST_GHIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist)); // R8

  AST_AGREE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_local == pred_global) |-> (pred_taken == pred_local)); // R4

  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (upd_local == upd_global)) |-> (cho_nxt == cho_cur)); // R5

  AST_SEL_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (cho_cur == '1) |-> (cho_nxt != '0)); // R9

  AST_SEL_NO_WRAP_DN: assert property (@(posedge clk) disable iff (!rst_n)
    (cho_cur == '0) |-> (cho_nxt != '1)); // R9

endmodule

bind tournament_bp tournament_bp_chk #(.GHIST_W(GHIST_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .upd_valid(upd_valid), .upd_taken(upd_taken),
  .upd_local(upd_local), .upd_global(upd_global),
  .pred_local(pred_local), .pred_global(pred_global), .pred_taken(pred_taken),
  .ghist(ghist_q), .cho_cur(cho_cur), .cho_nxt(cho_nxt)
);

// File: tb/tournament_bp_tb.sv
module tournament_bp_tb;

  localparam int PC_W = 30;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] pred_pc = '0;
  logic            pred_taken, pred_local, pred_global;
  logic            upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic            upd_taken = 1'b0, upd_local = 1'b0, upd_global = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tournament_bp u_dut (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc),
    .pred_taken(pred_taken), .pred_local(pred_local), .pred_global(pred_global),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_local(upd_local), .upd_global(upd_global)
  );

  // Reference model built from the requirements
  logic [9:0]  m_lh  [1024];
  logic [2:0]  m_lc  [1024];
  logic [1:0]  m_gc  [4096];
  logic [1:0]  m_sc  [4096];
  logic [11:0] m_gh;

  function automatic logic [9:0] fold(input logic [PC_W-1:0] pc);
    logic [9:0] r = '0;
    for (int i = 0; i < PC_W; i++) r[i % 10] = r[i % 10] ^ pc[i];
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 1024; i++) begin m_lh[i] = '0; m_lc[i] = 3'd3; end
    for (int i = 0; i < 4096; i++) begin m_gc[i] = 2'd1; m_sc[i] = 2'd1; end
    m_gh = '0;
  endtask

  task automatic model_pred(input logic [PC_W-1:0] pc, output logic l, output logic g,
                            output logic t);
    l = (m_lc[m_lh[fold(pc)]] >= 3'd4);
    g = (m_gc[m_gh] >= 2'd2);
    t = (m_sc[m_gh] >= 2'd2) ? g : l;
  endtask

  task automatic model_update(input logic [PC_W-1:0] pc, input logic tk,
                              input logic l, input logic g);
    logic [9:0] s = fold(pc);
    logic [9:0] h = m_lh[s];
    if (l != g) begin
      if (g == tk) begin if (m_sc[m_gh] != 2'd3) m_sc[m_gh] = m_sc[m_gh] + 2'd1; end
      else         begin if (m_sc[m_gh] != 2'd0) m_sc[m_gh] = m_sc[m_gh] - 2'd1; end
    end
    if (tk) begin
      if (m_gc[m_gh] != 2'd3) m_gc[m_gh] = m_gc[m_gh] + 2'd1;
      if (m_lc[h] != 3'd7)    m_lc[h]    = m_lc[h] + 3'd1;
    end else begin
      if (m_gc[m_gh] != 2'd0) m_gc[m_gh] = m_gc[m_gh] - 2'd1;
      if (m_lc[h] != 3'd0)    m_lc[h]    = m_lc[h] - 3'd1;
    end
    m_lh[s] = {h[8:0], tk};
    m_gh    = {m_gh[10:0], tk};
  endtask

  task automatic check_pred(input logic [PC_W-1:0] pc, input string tag);
    logic l, g, t;
    model_pred(pc, l, g, t);
    checks++;
    if ({pred_taken, pred_local, pred_global} !== {t, l, g}) begin
      errors++;
      $display("FAIL %s pc=%h: taken/local/global got %b%b%b expected %b%b%b",
               tag, pc, pred_taken, pred_local, pred_global, t, l, g);
    end
  endtask

  // Predict one branch, check it, then resolve it
  task automatic do_branch(input logic [PC_W-1:0] pc, input logic tk, input string tag);
    logic l, g, t;
    @(negedge clk);
    pred_pc = pc;
    #1;
    check_pred(pc, tag);
    model_pred(pc, l, g, t);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_local = l; upd_global = g;
    @(posedge clk);
    model_update(pc, tk, l, g);
    #1;
    upd_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [PC_W-1:0] pcs [4] = '{30'h0, 30'h1, 30'h3FF, 30'h2AAAAAAA};
    foreach (pcs[i]) begin
      @(negedge clk);
      pred_pc = pcs[i];
      #1;
      checks++;
      if ({pred_taken, pred_local, pred_global} !== 3'b000) begin
        errors++;
        $display("FAIL R1 pc=%h: got %b%b%b expected 000", pcs[i],
                 pred_taken, pred_local, pred_global);
      end
    end
  endtask

  task automatic t_taken_run();
    for (int i = 0; i < 30; i++) do_branch(30'h100, 1'b1, "R3/R9 taken run");
    @(negedge clk); pred_pc = 30'h100; #1;
    checks++;
    if (pred_global !== 1'b1) begin
      errors++;
      $display("FAIL R3 global after taken run: got %b expected 1", pred_global);
    end
  endtask

  task automatic t_untaken_run();
    for (int i = 0; i < 30; i++) do_branch(30'h77, 1'b0, "R9 not-taken run");
    @(negedge clk); pred_pc = 30'h77; #1;
    checks++;
    if ({pred_taken, pred_global} !== 2'b00) begin
      errors++;
      $display("FAIL R9 after not-taken run: got %b%b expected 00", pred_taken, pred_global);
    end
  endtask

  task automatic t_loop();
    for (int r = 0; r < 25; r++)
      for (int k = 0; k < 8; k++) do_branch(30'h2A5, (k != 7), "R2/R4/R5 loop");
  endtask

  task automatic t_corr();
    logic [7:0] lfsr = 8'hA5;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      do_branch(30'h3000, lfsr[0], "R6 correlated lead");
      do_branch(30'h3001, lfsr[0], "R5/R6 correlated follow");
    end
  endtask

  task automatic t_idle();
    @(negedge clk);
    upd_valid = 1'b0; upd_pc = 30'h100; upd_taken = 1'b0; upd_local = 1'b1; upd_global = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    pred_pc = 30'h100; #1; check_pred(30'h100, "R8 idle hold");
    pred_pc = 30'h2A5; #1; check_pred(30'h2A5, "R8 idle hold");
    pred_pc = 30'h3001; #1; check_pred(30'h3001, "R8 idle hold");
  endtask

  task automatic t_same_cycle();
    for (int i = 0; i < 6; i++) begin
      logic l, g, t;
      @(negedge clk);
      pred_pc = 30'h555;
      model_pred(30'h555, l, g, t);
      upd_valid = 1'b1; upd_pc = 30'h555; upd_taken = 1'b1; upd_local = l; upd_global = g;
      #1;
      check_pred(30'h555, "R7 before edge");
      @(posedge clk);
      model_update(30'h555, 1'b1, l, g);
      #1;
      upd_valid = 1'b0;
      #1;
      check_pred(30'h555, "R7 after edge");
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_taken_run();
    t_untaken_run();
    t_loop();
    t_corr();
    t_idle();
    t_same_cycle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule